// File: doc/BRIEF.md
# Cross-Coupled Four-Unit Operand Datapath

This block is a single-stage clocked datapath built from four function units. Each unit owns one signed 16-bit result register, and those four registers are the whole state of the block. On every clock edge the block takes in one complete input set: an external 16-bit sample, a 2-bit operation code for unit 0, and two 3-bit operand selects for each unit. Each unit uses its selects to pick two operands from a shared operand pool. It applies its operation and loads the result into its own register on that same edge.

The pool gives each unit the external sample, the constants zero and one, and the registered results of all four units. This lets the caller chain the units into short computations across cycles, including feedback of a unit onto itself. Units 1 to 3 have fixed operations (add, subtract, multiply). Unit 0 is programmable through the operation code. The visible output is the register of unit 3.

There is no flow control. Every cycle consumes a fresh input set, and the output changes only at clock edges.

Top module: `fu_mesh_datapath`

## Requirements
- R1: A synchronous active-high reset clears all four unit registers to 0, so the output reads 0 after the reset edge.
- R2: Select code s picks a pool entry as follows: 0 the external sample, 1 the constant 0, 2 the constant 1, and 3, 4, 5, 6 the registered results of units 0, 1, 2, 3. The selects for unit k occupy bits [3k+2:3k] of the first-operand and second-operand select ports.
- R3: Select code 7 supplies the value 0 as the operand.
- R4: Unit 1 loads the sum of its operands, wrapping in 16-bit two's complement.
- R5: Unit 2 loads first operand minus second operand, wrapping in 16-bit two's complement.
- R6: Unit 3 loads the low 16 bits of the product of its operands.
- R7: With operation code 00, unit 0 loads its first operand shifted left logically by its second operand, read as unsigned. Any amount of 16 or more yields 0.
- R8: With operation code 01, unit 0 loads the bitwise XOR of its operands.
- R9: With operation code 10, unit 0 loads 1 when its operands are equal and 0 otherwise.
- R10: Operation code 11 makes unit 0 load 0.
- R11: All four registers load on the same edge, one input set per cycle. The output is the register of unit 3, so it shows the unit-3 result computed from the previous cycle's inputs and does not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers load on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sample_in | input | 16 | External signed sample, pool entry 0 |
| op0_in | input | 2 | Operation code for unit 0 |
| sel_a_in | input | 12 | First-operand select codes, 3 bits per unit |
| sel_b_in | input | 12 | Second-operand select codes, 3 bits per unit |
| result_out | output | 16 | Current contents of the unit-3 register |

## Verification
Only unit 3 is visible at the pins. The bench therefore reads any other unit by routing that unit's register into unit 3 multiplied by the constant one, while the remaining units feed back onto themselves so they hold. The corner cases it targets are these:
- Shift amounts of 15, 16 and 0xFFFF. A design that masks the amount to four bits would return a shifted value instead of 0.
- Signed wrap of the adder at 0x7FFF + 1, and a product whose only set bits lie above bit 15.
- Operand order of the subtractor. A swapped subtractor gives the negated difference.
- Select code 7. A design that indexes past the pool could return the external sample.
- The reserved operation code. A design that falls through to another operation would give a nonzero result.
- Whether the output moves before the edge. A combinational output would fail this check.

// File: rtl/fudp_pkg.sv
package fudp_pkg;
  localparam int DATA_W  = 16;
  localparam int SEL_W   = 3;
  localparam int N_UNITS = 4;
  // pool: sample, zero, one, then one entry per unit register
  localparam int POOL_FIXED = 3;
  localparam int POOL_N     = POOL_FIXED + N_UNITS;
  localparam int POOL_SLOTS = 1 << SEL_W;

  typedef enum logic [1:0] {
    OP_SHL = 2'b00,
    OP_XOR = 2'b01,
    OP_EQ  = 2'b10,
    OP_RSV = 2'b11
  } op0_e;

  typedef enum logic [1:0] {
    FIX_ADD = 2'd0,
    FIX_SUB = 2'd1,
    FIX_MUL = 2'd2
  } fixed_kind_e;

  function automatic fixed_kind_e kind_of_unit(input int k);
    case ((k - 1) % 3)
      0:       return FIX_ADD;
      1:       return FIX_SUB;
      default: return FIX_MUL;
    endcase
  endfunction
endpackage

// File: rtl/fudp_operand_sel.sv
module fudp_operand_sel #(
  parameter int W       = 16,
  parameter int SEL_W   = 3,
  parameter int N_UNITS = 4
) (
  input  logic [SEL_W-1:0]     sel,
  input  logic [W-1:0]         sample,
  input  logic [N_UNITS*W-1:0] regs_flat,
  output logic [W-1:0]         opnd
);
  localparam int SLOTS  = 1 << SEL_W;
  localparam int FIXED  = 3;
  localparam int USED   = FIXED + N_UNITS;

  logic [W-1:0] pool [SLOTS];

  // pool padded to a power of two; unused slots read as zero
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    if (s == 0) begin : g_sample
      assign pool[s] = sample;
    end else if (s == 1) begin : g_zero
      assign pool[s] = '0;
    end else if (s == 2) begin : g_one
      assign pool[s] = W'(1);
    end else if (s < USED) begin : g_reg
      assign pool[s] = regs_flat[(s-FIXED)*W +: W];
    end else begin : g_pad
      assign pool[s] = '0;
    end
  end

  assign opnd = pool[sel];
endmodule

// File: rtl/fudp_unit0_alu.sv
module fudp_unit0_alu
  import fudp_pkg::*;
#(
  parameter int W = 16
) (
  input  op0_e         op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  localparam int SH_W = $clog2(W);
  localparam logic [W-1:0] SH_LIMIT = W;

  logic [W-1:0] shl_res;

  always_comb begin
    if (b >= SH_LIMIT) shl_res = '0;
    else               shl_res = a << b[SH_W-1:0];
  end

  always_comb begin
    case (op)
      OP_SHL:  y = shl_res;
      OP_XOR:  y = a ^ b;
      OP_EQ:   y = (a == b) ? W'(1) : '0;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/fudp_fixed_unit.sv
module fudp_fixed_unit
  import fudp_pkg::*;
#(
  parameter int          W    = 16,
  parameter fixed_kind_e KIND = FIX_ADD
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  if (KIND == FIX_ADD) begin : g_add
    assign y = a + b;
  end else if (KIND == FIX_SUB) begin : g_sub
    assign y = a - b;
  end else begin : g_mul
    // low half of the product is identical for signed and unsigned
    assign y = a * b;
  end
endmodule

// File: rtl/fu_mesh_datapath.sv
module fu_mesh_datapath
  import fudp_pkg::*;
#(
  parameter int W     = DATA_W,
  parameter int SW    = SEL_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [W-1:0]          sample_in,
  input  logic [1:0]            op0_in,
  input  logic [N_UNITS*SW-1:0] sel_a_in,
  input  logic [N_UNITS*SW-1:0] sel_b_in,
  output logic [W-1:0]          result_out
);
  localparam int NU = N_UNITS;

  logic [NU-1:0][W-1:0] unit_q;
  logic [NU-1:0][W-1:0] unit_d;
  logic [NU-1:0][W-1:0] opa;
  logic [NU-1:0][W-1:0] opb;
  logic [NU*W-1:0]      regs_flat;
  op0_e                 op0;

  assign regs_flat = unit_q;
  assign op0       = op0_e'(op0_in);

  for (genvar k = 0; k < NU; k++) begin : g_unit
    fudp_operand_sel #(.W(W), .SEL_W(SW), .N_UNITS(NU)) u_sel_a (
      .sel(sel_a_in[k*SW +: SW]), .sample(sample_in),
      .regs_flat(regs_flat), .opnd(opa[k])
    );
    fudp_operand_sel #(.W(W), .SEL_W(SW), .N_UNITS(NU)) u_sel_b (
      .sel(sel_b_in[k*SW +: SW]), .sample(sample_in),
      .regs_flat(regs_flat), .opnd(opb[k])
    );
    if (k == 0) begin : g_prog
      fudp_unit0_alu #(.W(W)) u_alu (
        .op(op0), .a(opa[k]), .b(opb[k]), .y(unit_d[k])
      );
    end else begin : g_fixed
      fudp_fixed_unit #(.W(W), .KIND(kind_of_unit(k))) u_fix (
        .a(opa[k]), .b(opb[k]), .y(unit_d[k])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (rst) unit_q <= '0;
    else     unit_q <= unit_d;
  end

  assign result_out = unit_q[NU-1];

  // R1: reset empties the state
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (unit_q == '0) && (result_out == '0));

  // R11: output is the registered unit-3 result of the prior cycle
  a_r11_out_lags: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> result_out == $past(unit_d[NU-1]));

  // R4: adder wraps in 16 bits
  a_r4_add_wrap: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> unit_q[1] == W'($past(opa[1]) + $past(opb[1])));

  // R3: code 7 on both adder operands gives zero
  a_r3_oob_zero: assert property (@(posedge clk) disable iff (rst)
    (sel_a_in[SW +: SW] == '1 && sel_b_in[SW +: SW] == '1) |=> unit_q[1] == '0);

  // R9: equality result is boolean
  a_r9_eq_boolean: assert property (@(posedge clk) disable iff (rst)
    (op0_in == 2'b10) |=> unit_q[0] <= W'(1));

  // R10: reserved code loads zero
  a_r10_rsv_zero: assert property (@(posedge clk) disable iff (rst)
    (op0_in == 2'b11) |=> unit_q[0] == '0);
endmodule

// File: tb/fu_mesh_datapath_test.sv
module fu_mesh_datapath_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] sample_in = '0;
  logic [1:0]  op0_in = '0;
  logic [11:0] sel_a_in = '0;
  logic [11:0] sel_b_in = '0;
  logic [15:0] result_out;

  fu_mesh_datapath uut (
    .clk(clk), .rst(rst), .sample_in(sample_in), .op0_in(op0_in),
    .sel_a_in(sel_a_in), .sel_b_in(sel_b_in), .result_out(result_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  logic [15:0] m [4];

  // stimulus table: sample, op code, first selects, second selects
  localparam logic [15:0] TX [NV] = '{16'h0005, 16'hFFFD, 16'h1234, 16'h8000, 16'h00FF, 16'h7777};
  localparam logic [1:0]  TO [NV] = '{2'b01, 2'b00, 2'b10, 2'b01, 2'b00, 2'b10};
  localparam logic [11:0] TA [NV] = '{
    {3'd0,3'd0,3'd0,3'd0}, {3'd4,3'd3,3'd5,3'd0}, {3'd6,3'd0,3'd6,3'd3},
    {3'd5,3'd4,3'd0,3'd6}, {3'd3,3'd6,3'd5,3'd0}, {3'd0,3'd5,3'd4,3'd4}};
  localparam logic [11:0] TB [NV] = '{
    {3'd2,3'd2,3'd2,3'd2}, {3'd0,3'd6,3'd3,3'd2}, {3'd0,3'd4,3'd0,3'd0},
    {3'd3,3'd0,3'd2,3'd0}, {3'd4,3'd2,3'd0,3'd3}, {3'd6,3'd1,3'd5,3'd4}};

  function automatic logic [15:0] pool_val(input logic [2:0] s, input logic [15:0] x);
    case (s)
      3'd0: return x;
      3'd1: return 16'd0;
      3'd2: return 16'd1;
      3'd3: return m[0];
      3'd4: return m[1];
      3'd5: return m[2];
      3'd6: return m[3];
      default: return 16'd0;
    endcase
  endfunction

  function automatic logic [15:0] ref_u0(input logic [1:0] op, input logic [15:0] a, input logic [15:0] b);
    case (op)
      2'b00: return (b >= 16'd16) ? 16'd0 : 16'(a << b);
      2'b01: return a ^ b;
      2'b10: return (a == b) ? 16'd1 : 16'd0;
      default: return 16'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic step(input logic [15:0] x, input logic [1:0] op,
                      input logic [11:0] sa, input logic [11:0] sb, input string tag);
    logic [15:0] nx [4];
    sample_in = x; op0_in = op; sel_a_in = sa; sel_b_in = sb;
    for (int k = 0; k < 4; k++) begin
      logic [15:0] a, b;
      a = pool_val(sa[k*3 +: 3], x);
      b = pool_val(sb[k*3 +: 3], x);
      case (k)
        0: nx[k] = ref_u0(op, a, b);
        1: nx[k] = a + b;
        2: nx[k] = a - b;
        default: nx[k] = 16'(a * b);
      endcase
    end
    @(posedge clk);
    for (int k = 0; k < 4; k++) m[k] = nx[k];
    @(negedge clk);
    check(tag, result_out, m[3]);
  endtask

  // others feed back onto themselves; unit 3 copies unit k times one
  task automatic peek(input int k, input logic [15:0] exp, input string tag);
    step(16'h0, 2'b01, {3'(3 + k), 3'd5, 3'd4, 3'd3}, {3'd2, 3'd1, 3'd1, 3'd1}, tag);
    check(tag, result_out, exp);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) m[k] = '0;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 reset output", result_out, 16'h0000);
    rst = 1'b0;

    // table walk with reference model
    for (int i = 0; i < NV; i++) step(TX[i], TO[i], TA[i], TB[i], "R2 table vector");

    // R4 add wrap
    step(16'h7FFF, 2'b01, {3'd6,3'd5,3'd0,3'd3}, {3'd2,3'd1,3'd2,3'd1}, "R4 add");
    peek(1, 16'h8000, "R4 add wrap");
    // R5 operand order of subtract: 1 - 3
    step(16'h0003, 2'b01, {3'd6,3'd2,3'd4,3'd3}, {3'd2,3'd0,3'd1,3'd1}, "R5 sub");
    peek(2, 16'hFFFE, "R5 sub order");
    // R6 multiply
    step(16'hFFFE, 2'b01, {3'd0,3'd5,3'd4,3'd3}, {3'd0,3'd1,3'd1,3'd1}, "R6 mul");
    check("R6 mul -2*-2", result_out, 16'h0004);
    step(16'h0100, 2'b01, {3'd0,3'd5,3'd4,3'd3}, {3'd0,3'd1,3'd1,3'd1}, "R6 mul");
    check("R6 mul low half", result_out, 16'h0000);
    // R2 constant zero entry
    step(16'h1111, 2'b01, {3'd0,3'd5,3'd4,3'd3}, {3'd1,3'd1,3'd1,3'd1}, "R2 zero entry");
    check("R2 x*0", result_out, 16'h0000);

    // R7 shift: amount 15 from unit 1
    step(16'h000F, 2'b01, {3'd6,3'd5,3'd0,3'd3}, {3'd2,3'd1,3'd1,3'd1}, "R7 setup");
    step(16'h0000, 2'b00, {3'd6,3'd5,3'd4,3'd2}, {3'd2,3'd1,3'd1,3'd4}, "R7 shl");
    peek(0, 16'h8000, "R7 shl by 15");
    step(16'h0010, 2'b01, {3'd6,3'd5,3'd0,3'd3}, {3'd2,3'd1,3'd1,3'd1}, "R7 setup");
    step(16'h0000, 2'b00, {3'd6,3'd5,3'd4,3'd2}, {3'd2,3'd1,3'd1,3'd4}, "R7 shl");
    peek(0, 16'h0000, "R7 shl by 16");
    step(16'h8001, 2'b00, {3'd6,3'd5,3'd4,3'd0}, {3'd2,3'd1,3'd1,3'd2}, "R7 shl");
    peek(0, 16'h0002, "R7 shl by 1");
    step(16'hFFFF, 2'b01, {3'd6,3'd5,3'd0,3'd3}, {3'd2,3'd1,3'd1,3'd1}, "R7 setup");
    step(16'h0000, 2'b00, {3'd6,3'd5,3'd4,3'd2}, {3'd2,3'd1,3'd1,3'd4}, "R7 shl");
    peek(0, 16'h0000, "R7 shl by FFFF");

    // R8 xor with own register (2 from previous line of shifts? reload)
    step(16'h0002, 2'b01, {3'd6,3'd5,3'd4,3'd0}, {3'd2,3'd1,3'd1,3'd1}, "R8 setup");
    step(16'hA5A5, 2'b01, {3'd6,3'd5,3'd4,3'd0}, {3'd2,3'd1,3'd1,3'd3}, "R8 xor");
    peek(0, 16'hA5A7, "R8 xor");

    // R9 equality
    step(16'h1234, 2'b10, {3'd6,3'd5,3'd4,3'd0}, {3'd2,3'd1,3'd1,3'd0}, "R9 eq");
    peek(0, 16'h0001, "R9 equal");
    // R10 reserved right after a nonzero unit 0
    step(16'h0007, 2'b11, {3'd6,3'd5,3'd4,3'd0}, {3'd2,3'd1,3'd1,3'd0}, "R10 rsv");
    peek(0, 16'h0000, "R10 reserved");
    step(16'h0002, 2'b10, {3'd6,3'd5,3'd4,3'd0}, {3'd2,3'd1,3'd1,3'd2}, "R9 eq");
    peek(0, 16'h0000, "R9 not equal");

    // R3 select 7 is zero, not the sample
    step(16'h0064, 2'b01, {3'd7,3'd5,3'd7,3'd3}, {3'd0,3'd1,3'd2,3'd1}, "R3 sel7");
    check("R3 sel7 mul", result_out, 16'h0000);
    peek(1, 16'h0001, "R3 sel7 add");

    // R11 output holds until the edge
    step(16'h0042, 2'b01, {3'd0,3'd5,3'd4,3'd3}, {3'd2,3'd1,3'd1,3'd1}, "R11 load");
    sample_in = 16'h0099;
    #(CLK_PERIOD/4);
    check("R11 no change before edge", result_out, 16'h0042);
    step(16'h0099, 2'b01, {3'd0,3'd5,3'd4,3'd3}, {3'd2,3'd1,3'd1,3'd1}, "R11 after edge");
    check("R11 new value", result_out, 16'h0099);

    // R1 reset from a loaded state
    step(16'h5555, 2'b01, {3'd0,3'd0,3'd0,3'd0}, {3'd2,3'd2,3'd2,3'd2}, "R1 load");
    rst = 1'b1;
    @(posedge clk);
    for (int k = 0; k < 4; k++) m[k] = '0;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset output", result_out, 16'h0000);
    for (int k = 0; k < 3; k++) peek(k, 16'h0000, "R1 register cleared");

    done = 1;
    summary();
  end
endmodule